// File: doc/BRIEF.md
# System Control Port with Speaker Gate

This block is the board-control corner of a parallel peripheral interface. Software writes one 8-bit control byte. The block splits that byte into a keyboard enable, a 2-bit keyboard mode, a bank select for the configuration switches, and two speaker controls.

Two read ports are kept up to date on every clock. The status port shows one of two configuration-switch banks, picked by the bank select bit. The keyboard port shows either the incoming keyboard byte or a fixed switch pattern.

The speaker line mixes the interval-timer channel-2 output with the two speaker controls and is registered. A one-cycle pulse marks each change of the line, so downstream audio logic only has to act on edges.

Top module: `sysport_ctrl`

## Requirements
- R1: After reset the control byte is 8'h00. That gives keyboard reads enabled, keyboard mode 2'b00, the low switch bank, the speaker line at 0 and no toggle pulse.
- R2: One cycle after a control write, `kbd_rd_en` equals the inverse of written bit 7, and `kbd_mode` equals written bits 7:6.
- R3: With control bit 3 set, `status_rdata` reads SW_BANK_HI (default 8'h03: display type 2'b11 in bits 1:0, drive count 0 in bits 3:2). It follows one cycle after the control byte changes.
- R4: With control bit 3 clear, `status_rdata` reads SW_BANK_LO (default 8'h0C: memory size code in bits 3:2).
- R5: With control bit 7 clear, `kbd_rdata` returns `kbd_din` one cycle later. With bit 7 set, it returns KBD_OFF_PAT (default 8'h3C).
- R6: `spk_out` equals (control bit 0 AND `timer2_out`) XOR control bit 1, registered one cycle after its inputs.
- R7: `spk_toggle` is high for exactly the cycle in which `spk_out` takes a new value, and is low otherwise.
- R8: While `ctrl_we` is low, `ctrl_wdata` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte |
| kbd_din | input | 8 | Byte from the keyboard receiver |
| timer2_out | input | 1 | Interval timer channel-2 output |
| kbd_rd_en | output | 1 | Keyboard reads enabled |
| kbd_mode | output | 2 | Keyboard mode field |
| status_rdata | output | 8 | Status port read value (switch bank) |
| kbd_rdata | output | 8 | Keyboard port read value |
| spk_out | output | 1 | Registered speaker line |
| spk_toggle | output | 1 | One-cycle pulse on each speaker change |

## Verification
A corrupted control register shows up at the ports one cycle after the faulty write. A wrong bit 3 flips `status_rdata` between the two banks. A wrong bit 7 swaps keyboard data for the fixed pattern and flips `kbd_rd_en`. A wrong bit 0 or bit 1 makes `spk_out` disagree with the mix formula on the next timer level, and a stale speaker register is caught through a missing or extra `spk_toggle` pulse in the same cycle.

// File: rtl/sysport_pkg.sv
package sysport_pkg;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic       kbd_off;    // bit 7
    logic [1:0] kbd_mode;   // bits 7:6
    logic       bank_hi;    // bit 3
    logic       spk_level;  // bit 1
    logic       spk_gate;   // bit 0
  } ctrl_fields_t;

  function automatic ctrl_fields_t split_ctrl(input logic [CTRL_W-1:0] b);
    ctrl_fields_t f;
    f.kbd_off   = b[7];
    f.kbd_mode  = b[7:6];
    f.bank_hi   = b[3];
    f.spk_level = b[1];
    f.spk_gate  = b[0];
    return f;
  endfunction
endpackage

// File: rtl/sysport_creg.sv
module sysport_creg
  import sysport_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q,
  output ctrl_fields_t fields
);
  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= '0;
    else if (we) ctrl_q <= wdata;
  end

  assign fields = split_ctrl(ctrl_q);
endmodule

// File: rtl/sysport_readback.sv
module sysport_readback
  import sysport_pkg::*;
#(
  parameter int          W           = CTRL_W,
  parameter logic [W-1:0] SW_BANK_HI  = 8'h03,
  parameter logic [W-1:0] SW_BANK_LO  = 8'h0C,
  parameter logic [W-1:0] KBD_OFF_PAT = 8'h3C
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_fields_t fields,
  input  logic [W-1:0] kbd_din,
  output logic [W-1:0] status_rdata,
  output logic [W-1:0] kbd_rdata,
  output logic         kbd_rd_en,
  output logic [1:0]   kbd_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_rdata <= SW_BANK_LO;
      kbd_rdata    <= '0;
      kbd_rd_en    <= 1'b1;
      kbd_mode     <= 2'b00;
    end else begin
      status_rdata <= fields.bank_hi ? SW_BANK_HI : SW_BANK_LO;
      kbd_rdata    <= fields.kbd_off ? KBD_OFF_PAT : kbd_din;
      kbd_rd_en    <= ~fields.kbd_off;
      kbd_mode     <= fields.kbd_mode;
    end
  end
endmodule

// File: rtl/sysport_spkr.sv
module sysport_spkr
  import sysport_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  ctrl_fields_t fields,
  input  logic         timer2_out,
  output logic         spk_out,
  output logic         spk_toggle
);
  logic mix_d;
  assign mix_d = (fields.spk_gate & timer2_out) ^ fields.spk_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      spk_out    <= 1'b0;
      spk_toggle <= 1'b0;
    end else begin
      spk_out    <= mix_d;
      spk_toggle <= mix_d ^ spk_out;
    end
  end
endmodule

// File: rtl/sysport_ctrl.sv
module sysport_ctrl
  import sysport_pkg::*;
#(
  parameter logic [7:0] SW_BANK_HI  = 8'h03,
  parameter logic [7:0] SW_BANK_LO  = 8'h0C,
  parameter logic [7:0] KBD_OFF_PAT = 8'h3C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic [7:0] kbd_din,
  input  logic       timer2_out,
  output logic       kbd_rd_en,
  output logic [1:0] kbd_mode,
  output logic [7:0] status_rdata,
  output logic [7:0] kbd_rdata,
  output logic       spk_out,
  output logic       spk_toggle
);
  logic [CTRL_W-1:0] ctrl_q;
  ctrl_fields_t      fields;

  sysport_creg #(.W(CTRL_W)) u_creg (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .fields(fields)
  );

  sysport_readback #(
    .W(CTRL_W), .SW_BANK_HI(SW_BANK_HI), .SW_BANK_LO(SW_BANK_LO),
    .KBD_OFF_PAT(KBD_OFF_PAT)
  ) u_rb (
    .clk(clk), .rst(rst), .fields(fields), .kbd_din(kbd_din),
    .status_rdata(status_rdata), .kbd_rdata(kbd_rdata),
    .kbd_rd_en(kbd_rd_en), .kbd_mode(kbd_mode)
  );

  sysport_spkr u_spk (
    .clk(clk), .rst(rst), .fields(fields), .timer2_out(timer2_out),
    .spk_out(spk_out), .spk_toggle(spk_toggle)
  );
endmodule

// File: rtl/sysport_ctrl_chk.sv
module sysport_ctrl_chk #(
  parameter logic [7:0] SW_BANK_HI  = 8'h03,
  parameter logic [7:0] SW_BANK_LO  = 8'h0C,
  parameter logic [7:0] KBD_OFF_PAT = 8'h3C
) (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_we,
  input logic [7:0] ctrl_q,
  input logic [7:0] kbd_din,
  input logic       timer2_out,
  input logic       kbd_rd_en,
  input logic [7:0] status_rdata,
  input logic [7:0] kbd_rdata,
  input logic       spk_out,
  input logic       spk_toggle
);
  p_mode_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> kbd_rd_en == !$past(ctrl_q[7]));

  p_bank_hi_r3: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[3] |=> status_rdata == SW_BANK_HI);

  p_bank_lo_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[3] |=> status_rdata == SW_BANK_LO);

  p_kbd_on_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[7] |=> kbd_rdata == $past(kbd_din));

  p_kbd_off_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[7] |=> kbd_rdata == KBD_OFF_PAT);

  p_mix_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> spk_out == $past((ctrl_q[0] & timer2_out) ^ ctrl_q[1]));

  p_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> spk_toggle == (spk_out != $past(spk_out)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(ctrl_q));
endmodule

bind sysport_ctrl sysport_ctrl_chk #(
  .SW_BANK_HI(SW_BANK_HI), .SW_BANK_LO(SW_BANK_LO), .KBD_OFF_PAT(KBD_OFF_PAT)
) u_chk (
  .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_q(ctrl_q),
  .kbd_din(kbd_din), .timer2_out(timer2_out), .kbd_rd_en(kbd_rd_en),
  .status_rdata(status_rdata), .kbd_rdata(kbd_rdata),
  .spk_out(spk_out), .spk_toggle(spk_toggle)
);

// File: tb/test_sysport_ctrl.sv
module test_sysport_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] kbd_din = 8'h00;
  logic       timer2_out = 1'b0;
  logic       kbd_rd_en, spk_out, spk_toggle;
  logic [1:0] kbd_mode;
  logic [7:0] status_rdata, kbd_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysport_ctrl i_sysport_ctrl (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .kbd_din(kbd_din), .timer2_out(timer2_out), .kbd_rd_en(kbd_rd_en),
    .kbd_mode(kbd_mode), .status_rdata(status_rdata), .kbd_rdata(kbd_rdata),
    .spk_out(spk_out), .spk_toggle(spk_toggle)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // write a control byte, then wait until registered outputs reflect it
  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = ~v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 status", status_rdata, 8'h0C);
    check("R1 kbd_en", {7'd0, kbd_rd_en}, 8'd1);
    check("R1 mode", {6'd0, kbd_mode}, 8'd0);
    check("R1 spk", {6'd0, spk_out, spk_toggle}, 8'd0);
  endtask

  task automatic t_decode();
    wr_ctrl(8'h80);
    check("R2 kbd_en off", {7'd0, kbd_rd_en}, 8'd0);
    check("R2 mode 10", {6'd0, kbd_mode}, 8'd2);
    wr_ctrl(8'hC0);
    check("R2 mode 11", {6'd0, kbd_mode}, 8'd3);
    wr_ctrl(8'h40);
    check("R2 kbd_en on", {7'd0, kbd_rd_en}, 8'd1);
    check("R2 mode 01", {6'd0, kbd_mode}, 8'd1);
  endtask

  task automatic t_banks();
    wr_ctrl(8'h08);
    check("R3 bank hi", status_rdata, 8'h03);
    wr_ctrl(8'h00);
    check("R4 bank lo", status_rdata, 8'h0C);
  endtask

  task automatic t_kbd();
    wr_ctrl(8'h00);
    kbd_din = 8'hA5; @(negedge clk);
    check("R5 kbd data", kbd_rdata, 8'hA5);
    kbd_din = 8'h5A; @(negedge clk);
    check("R5 kbd data 2", kbd_rdata, 8'h5A);
    wr_ctrl(8'h80);
    check("R5 kbd pattern", kbd_rdata, 8'h3C);
  endtask

  task automatic t_speaker();
    wr_ctrl(8'h00);
    timer2_out = 1'b1; @(negedge clk);
    check("R6 gate closed", {7'd0, spk_out}, 8'd0);
    check("R7 no pulse", {7'd0, spk_toggle}, 8'd0);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 8'h01;
    @(negedge clk); ctrl_we = 1'b0;
    @(negedge clk);
    check("R6 gate open", {7'd0, spk_out}, 8'd1);
    check("R7 pulse", {7'd0, spk_toggle}, 8'd1);
    @(negedge clk);
    check("R7 pulse one cycle", {7'd0, spk_toggle}, 8'd0);
    timer2_out = 1'b0; @(negedge clk);
    check("R6 follows timer", {7'd0, spk_out}, 8'd0);
    check("R7 pulse fall", {7'd0, spk_toggle}, 8'd1);
    wr_ctrl(8'h03);
    check("R6 level only", {7'd0, spk_out}, 8'd1);
    timer2_out = 1'b1; @(negedge clk);
    check("R6 xor", {7'd0, spk_out}, 8'd0);
    wr_ctrl(8'h02);
    check("R6 level ungated", {7'd0, spk_out}, 8'd1);
  endtask

  task automatic t_ignore();
    wr_ctrl(8'h08);
    @(negedge clk); ctrl_we = 1'b0; ctrl_wdata = 8'h83;
    @(negedge clk); @(negedge clk);
    check("R8 status held", status_rdata, 8'h03);
    check("R8 kbd_en held", {7'd0, kbd_rd_en}, 8'd1);
    check("R8 spk held", {7'd0, spk_out}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_banks();
    t_kbd();
    timer2_out = 1'b0;
    t_speaker();
    timer2_out = 1'b0;
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule